// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the digital control for a 12-bit successive-approximation converter that talks over a three-wire, output-only serial port. A falling active-low chip select opens a transfer. The block runs a short sample phase and resolves the result one bit at a time by driving trial codes to an external capacitive DAC and reading back a single comparator decision. Each decided bit is shifted out as soon as it is known. There is no configuration input, and every conversion is single-channel and unipolar.

The frame on the data line starts with a low null bit, which is held through the sampling edges. The result follows most significant bit first, and then again least significant bit first. The LSB is sent only once, because the two halves share it. Raising chip select clears every register, floats the data line and asserts the shutdown flag.

The serial clock and chip select are sampled by a faster system clock `clk`, which is synchronous to them. A serial-clock falling edge is recognised in the system cycle where the sampled clock goes from 1 to 0, and all outputs change in that cycle's register update.

Top module: `serial_adc_seq`

## Requirements
- R1: After synchronous active-low reset, `dout_oe` is 0, `shutdown` is 1 and `trial` is 0.
- R2: While `cs_n` is high, the next system cycle shows `dout_oe` = 0, `shutdown` = 1 and `trial` = 0. Serial-clock edges seen in that state have no effect.
- R3: While `cs_n` is low, `shutdown` reads 0 from the following system cycle.
- R4: `dout`, `dout_oe` and `trial` change only in the system cycle after a detected serial-clock falling edge, or because chip select is high.
- R5: After chip select falls, the first `SETUP_EDGES` serial-clock falling edges (default 1) leave `dout_oe` at 0. The next falling edge (edge 0) sets `dout_oe` to 1 with `dout` = 0.
- R6: `dout` stays 0 (the null bit) on edge 0 and on the `SAMPLE_EDGES` sampling edges after it. At the defaults this covers edges 0 to 2.
- R7: On edges 3 to 14, `dout` carries result bits B11 down to B0. Each bit equals the comparator input on that edge, where `cmp` = 1 means the analog input is at or above `trial`.
- R8: On the last sampling edge, `trial` becomes 0x800. On each decision edge, the tested bit is kept or cleared according to `cmp` and the next lower bit is set. After B0, `trial` equals the result.
- R9: On edges 15 to 25, `dout` carries B1 up to B11.
- R10: If chip select stays low after edge 25, `dout` stays driven to 0 on every later edge and no new conversion starts.
- R11: If chip select rises in the middle of a frame, the partial conversion is dropped. The next frame reports only its own conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, sampled in the `clk` domain |
| cmp | input | 1 | Comparator decision, 1 when the input is at or above `trial` |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable for the data pad; 0 means high impedance |
| trial | output | DATA_W | Trial code driven to the DAC |
| shutdown | output | 1 | Power-down request, high while deselected |

## Verification
The assertions assume that `sclk` and `cs_n` are synchronous to `clk` and hold each level for several system cycles. They also assume that chip select changes only while the serial clock is high, so that a select edge and a clock edge never fall in the same system cycle. The bench drives both signals only at the falling edge of `clk`, holds every serial-clock phase for at least two system cycles, and moves chip select only while the serial clock is high. The comparator is an ideal compare of a stored input code against `trial`, so it settles long before the next serial-clock edge reads it.

// File: rtl/adc_seq_pkg.sv
// Shared types for the serial ADC output sequencer.
// Assumes: nothing beyond the users importing it.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_SAMPLE,
        PH_CONV,
        PH_TAIL,
        PH_DONE
    } phase_t;
endpackage

// File: rtl/adc_sclk_edge.sv
// Detects falling edges of the serial clock in the system clock domain.
// Assumes: sclk is already synchronous to clk and stable for >= 1 cycle per level.
module adc_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic fall
);
    logic sclk_q;

    // Hold the previous sampled level of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign fall = sclk_q & ~sclk;
endmodule

// File: rtl/adc_seq_ctrl.sv
// Phase controller: setup wait, sampling, MSB-first decisions, LSB-first tail.
// Assumes: fall is a one-cycle strobe; cs_n high acts as a full synchronous clear.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int SETUP_EDGES  = 1,
    parameter int SAMPLE_EDGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      fall,
    output phase_t                    phase,
    output logic [$clog2(DATA_W)-1:0] idx,
    output logic                      go,
    output logic                      sample_last
);
    localparam int IW  = $clog2(DATA_W);
    localparam int SW  = $clog2(SETUP_EDGES + 2);
    localparam int SMW = $clog2(SAMPLE_EDGES + 1);

    logic [SW-1:0]  setup_cnt;
    logic [SMW-1:0] samp_cnt;
    logic           setup_met;

    assign setup_met   = (setup_cnt >= SW'(SETUP_EDGES));
    assign sample_last = (samp_cnt == SMW'(SAMPLE_EDGES - 1));
    assign go          = fall && (phase != PH_IDLE) && !((phase == PH_SETUP) && !setup_met);

    // Advance the frame phase and its counters on qualified serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase     <= PH_IDLE;
            setup_cnt <= '0;
            samp_cnt  <= '0;
            idx       <= '0;
        end else begin
            case (phase)
                PH_IDLE: phase <= PH_SETUP;
                PH_SETUP: begin
                    if (go) begin
                        phase    <= PH_SAMPLE;
                        samp_cnt <= '0;
                    end else if (fall) begin
                        setup_cnt <= setup_cnt + 1'b1;
                    end
                end
                PH_SAMPLE: begin
                    if (go) begin
                        if (sample_last) begin
                            phase <= PH_CONV;
                            idx   <= IW'(DATA_W - 1);
                        end else begin
                            samp_cnt <= samp_cnt + 1'b1;
                        end
                    end
                end
                PH_CONV: begin
                    if (go) begin
                        if (idx == '0) begin
                            phase <= PH_TAIL;
                            idx   <= IW'(1);
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                end
                PH_TAIL: begin
                    if (go) begin
                        if (idx == IW'(DATA_W - 1)) phase <= PH_DONE;
                        else                        idx   <= idx + 1'b1;
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end
endmodule

// File: rtl/adc_sar_reg.sv
// Successive-approximation register: trial code for the DAC and decided result.
// Assumes: cmp is settled against the current trial code when go fires.
module adc_sar_reg
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      go,
    input  phase_t                    phase,
    input  logic                      sample_last,
    input  logic [$clog2(DATA_W)-1:0] idx,
    input  logic                      cmp,
    output logic [DATA_W-1:0]         trial,
    output logic [DATA_W-1:0]         result
);
    logic [DATA_W-1:0] bit_m;
    logic [DATA_W-1:0] msb_m;

    assign bit_m = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
    assign msb_m = {1'b1, {(DATA_W-1){1'b0}}};

    // Load the MSB trial, then keep or clear each bit and arm the next one.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            trial  <= '0;
            result <= '0;
        end else if (go) begin
            case (phase)
                PH_SAMPLE: if (sample_last) trial <= msb_m;
                PH_CONV: begin
                    trial  <= (trial & ~bit_m) | (cmp ? bit_m : '0) | (bit_m >> 1);
                    result <= result | (cmp ? bit_m : '0);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adc_dout_drv.sv
// Serial data driver: output enable, null bit, MSB-first bits, LSB-first tail.
// Assumes: result holds every bit at or above idx when the tail phase runs.
module adc_dout_drv
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      go,
    input  phase_t                    phase,
    input  logic [$clog2(DATA_W)-1:0] idx,
    input  logic                      cmp,
    input  logic [DATA_W-1:0]         result,
    output logic                      dout,
    output logic                      dout_oe
);
    // Drive the next frame bit on each qualified serial falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (go) begin
            dout_oe <= 1'b1;
            case (phase)
                PH_CONV: dout <= cmp;
                PH_TAIL: dout <= result[idx];
                default: dout <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/serial_adc_seq.sv
// Top of the serial ADC output sequencer.
// Assumes: sclk and cs_n are synchronous to clk; cs_n moves only while sclk is high.
module serial_adc_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int SETUP_EDGES  = 1,
    parameter int SAMPLE_EDGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              cmp,
    output logic              dout,
    output logic              dout_oe,
    output logic [DATA_W-1:0] trial,
    output logic              shutdown
);
    localparam int IW = $clog2(DATA_W);

    logic              fall;
    logic              go;
    logic              sample_last;
    phase_t            phase;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] result;

    adc_sclk_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .fall (fall)
    );

    adc_seq_ctrl #(
        .DATA_W      (DATA_W),
        .SETUP_EDGES (SETUP_EDGES),
        .SAMPLE_EDGES(SAMPLE_EDGES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .fall       (fall),
        .phase      (phase),
        .idx        (idx),
        .go         (go),
        .sample_last(sample_last)
    );

    adc_sar_reg #(.DATA_W(DATA_W)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .go         (go),
        .phase      (phase),
        .sample_last(sample_last),
        .idx        (idx),
        .cmp        (cmp),
        .trial      (trial),
        .result     (result)
    );

    adc_dout_drv #(.DATA_W(DATA_W)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .go     (go),
        .phase  (phase),
        .idx    (idx),
        .cmp    (cmp),
        .result (result),
        .dout   (dout),
        .dout_oe(dout_oe)
    );

    // Request power-down whenever the part is deselected or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) shutdown <= 1'b1;
        else                shutdown <= 1'b0;
    end
endmodule

// File: rtl/serial_adc_seq_chk.sv
// Port-level checker for serial_adc_seq, attached by bind below.
// Assumes: inputs are synchronous to clk, as the top module header states.
module serial_adc_seq_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sclk,
    input logic              dout,
    input logic              dout_oe,
    input logic [DATA_W-1:0] trial,
    input logic              shutdown
);
    // R2
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_oe && shutdown && (trial == '0)));

    // R3
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> !shutdown);

    // R4
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$fell(sclk)) |=> ($stable(dout) && $stable(dout_oe) && $stable(trial)));

    // R5
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sclk) |=> !$rose(dout_oe));

    // R6
    null_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout);
endmodule

bind serial_adc_seq serial_adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .dout    (dout),
    .dout_oe (dout_oe),
    .trial   (trial),
    .shutdown(shutdown)
);

// File: tb/sim_serial_adc_seq.sv
`timescale 1ns/1ps
module sim_serial_adc_seq;
    localparam int W     = 12;
    localparam int SETUP = 1;
    localparam int SAMP  = 2;
    localparam int FRAME = 1 + SAMP + 2 * W - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b1;
    logic [W-1:0] vin = '0;
    logic         cmp;
    logic         dout;
    logic         dout_oe;
    logic [W-1:0] trial;
    logic         shutdown;
    int           n_tests = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    assign cmp = (vin >= trial);

    serial_adc_seq u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .cmp     (cmp),
        .dout    (dout),
        .dout_oe (dout_oe),
        .trial   (trial),
        .shutdown(shutdown)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int k, input logic [W-1:0] v);
        if (k < 1 + SAMP)          return 1'b0;
        if (k < 1 + SAMP + W)      return v[W - 1 - (k - 1 - SAMP)];
        if (k < FRAME)             return v[k - (SAMP + W)];
        return 1'b0;
    endfunction

    function automatic string req_of(input int k);
        if (k < 1 + SAMP)     return "R6 null";
        if (k < 1 + SAMP + W) return "R7 msb-first";
        if (k < FRAME)        return "R9 lsb-first";
        return "R10 tail zero";
    endfunction

    task automatic sfall();
        @(negedge clk) sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic srise();
        sclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_conv(input logic [W-1:0] v, input int extra, input int abort_at);
        vin = v;
        @(negedge clk) cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(shutdown == 1'b0, "R3 shutdown low", int'(shutdown), 0);
        for (int s = 0; s < SETUP; s++) begin
            sfall();
            chk(dout_oe == 1'b0, "R5 setup edge floats", int'(dout_oe), 0);
            srise();
        end
        for (int k = 0; k < FRAME + extra; k++) begin
            if (k == abort_at) break;
            sfall();
            chk(dout_oe == 1'b1, "R5 output enabled", int'(dout_oe), 1);
            chk(dout == exp_bit(k, v), req_of(k), int'(dout), int'(exp_bit(k, v)));
            if (k == SAMP)
                chk(trial == {1'b1, {(W-1){1'b0}}}, "R8 msb trial", int'(trial), 1 << (W - 1));
            if (k == SAMP + W)
                chk(trial == v, "R8 final trial", int'(trial), int'(v));
            srise();
        end
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dout_oe == 1'b0 && shutdown == 1'b1 && trial == '0, "R2 deselect idle",
            int'({dout_oe, shutdown}), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(dout_oe == 1'b0 && shutdown == 1'b1 && trial == '0, "R1 reset state",
            int'({dout_oe, shutdown}), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dout_oe == 1'b0 && shutdown == 1'b1 && trial == '0, "R1 after reset",
            int'({dout_oe, shutdown}), 1);
        // R2: serial edges while deselected are ignored
        for (int i = 0; i < 3; i++) begin
            sfall();
            chk(dout_oe == 1'b0 && trial == '0 && shutdown == 1'b1, "R2 edges ignored",
                int'(dout_oe), 0);
            srise();
        end
        // Directed corner codes, R7 and R9
        run_conv(12'h000, 0, -1);
        run_conv(12'hFFF, 0, -1);
        run_conv(12'h800, 0, -1);
        run_conv(12'h7FF, 0, -1);
        run_conv(12'h001, 0, -1);
        run_conv(12'h555, 0, -1);
        // R10: chip select held low past the frame
        run_conv(12'hA5C, 5, -1);
        // R11: abort mid frame, then a fresh conversion
        run_conv(12'hABC, 0, 9);
        run_conv(12'h123, 0, -1);
        for (int n = 0; n < 30; n++) begin
            logic [W-1:0] rv;
            int           ex;
            rv = W'($urandom % 4096);
            ex = int'($urandom % 3);
            if (n % 7 == 3) run_conv(rv, 0, int'($urandom % FRAME));
            else            run_conv(rv, ex, -1);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule